// File: doc/BRIEF.md
# 2B1Q Superframe Transmit Framer

This block produces the transmit symbol stream of a two-wire digital subscriber line. A serial payload bit stream (B1, B2, D and maintenance bits, already ordered by the upstream logic) enters through a ready/valid handshake. The block packs the bits in pairs and maps each pair to one of four line levels. It sends one level per symbol strobe.

Each basic frame is 120 symbols long. Its first 9 symbols are a fixed synchronization word and the other 111 symbols carry 222 payload bits. Eight frames form a superframe. The first frame of a superframe marks the boundary by sending every sync symbol with its polarity inverted.

When payload is missing at the moment a payload symbol is due, the block sends a filler level and flags an underrun for that symbol. The block also outputs the frame index and a superframe-start marker alongside each symbol, so that downstream logic can align to the frame.

Top module: `dsl_superframe_tx`

## Requirements
- R1: `sym_stb` is a one-cycle pulse that occurs every CLKS_PER_SYM clock cycles. The first pulse comes CLKS_PER_SYM cycles after reset is released.
- R2: Each frame is 120 symbols. Symbols 0 to 8 are the sync word +3 +3 −3 −3 −3 +3 −3 +3 +3 in that order. Symbols 9 to 119 carry payload.
- R3: In frame index 0 every sync symbol is negated. In frame indices 1 to 7 the sync word is sent unchanged.
- R4: The first payload bit of a pair is the sign and the second is the magnitude. 10 gives +3 (code 3'b011), 11 gives +1 (3'b001), 01 gives −1 (3'b111) and 00 gives −3 (3'b101). `sym_level` is always one of these four codes.
- R5: `pay_ready` is low while the next symbol due is a sync symbol, on cycles where a strobe is issued, and once two bits are held. No bit is accepted at those times.
- R6: If a payload symbol is due and fewer than two bits are held, the block sends −3 and raises `underrun` with that strobe. Any single held bit is discarded.
- R7: `frame_num` gives the frame of the current symbol. It counts 0 to 7, advances after symbol 119 and wraps to 0. `sf_start` is high only with the strobe of symbol 0 of frame 0.
- R8: During reset `sym_stb`, `underrun`, `sf_start`, `pay_ready` and `frame_num` are all 0. The first symbol after reset is symbol 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pay_data | input | 1 | Serial payload bit |
| pay_valid | input | 1 | Payload bit valid |
| pay_ready | output | 1 | Block accepts a payload bit this cycle |
| sym_stb | output | 1 | Symbol strobe, one cycle |
| sym_level | output | 3 | Signed line level code of the current symbol |
| underrun | output | 1 | Current symbol is a filler sent for lack of payload |
| sf_start | output | 1 | Current symbol opens a superframe |
| frame_num | output | 3 | Frame index of the current symbol |

## Verification
The hardest case to reach is an underrun that arrives while exactly one bit of a pair is held. The partial bit must be dropped, and the next pair must start fresh. This only happens when valid is sparse enough that a symbol slot closes between the two bits of a pair. One stimulus phase therefore drives valid at about 30 % while the bench model tracks every accepted bit. Other phases starve a whole superframe-opening frame and run the stream at full and near-full rate over several superframe boundaries.

// File: rtl/dsl_superframe_tx.sv
module dsl_superframe_tx #(
  parameter int CLKS_PER_SYM = 4,
  parameter int SYMS_PER_FRAME = 120,
  parameter int SYNC_SYMS = 9,
  parameter int FRAMES_PER_SF = 8,
  parameter logic [SYNC_SYMS-1:0] SYNC_WORD = 9'b110001011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pay_data,
  input  logic pay_valid,
  output logic pay_ready,
  output logic sym_stb,
  output logic [2:0] sym_level,
  output logic underrun,
  output logic sf_start,
  output logic [$clog2(FRAMES_PER_SF)-1:0] frame_num
);
  localparam int DIVW = (CLKS_PER_SYM > 1) ? $clog2(CLKS_PER_SYM) : 1;
  localparam int SYMW = $clog2(SYMS_PER_FRAME);
  localparam int FRW  = $clog2(FRAMES_PER_SF);

  logic [DIVW-1:0] div_q;
  logic [SYMW-1:0] sym_idx;
  logic [FRW-1:0]  frame_q;
  logic [1:0]      pair_q;
  logic [1:0]      pair_cnt;
  logic            sgn, mag3;
  logic [SYNC_SYMS-1:0] sync_sh;

  wire tick    = (div_q == DIVW'(CLKS_PER_SYM - 1));
  wire in_info = (sym_idx >= SYMW'(SYNC_SYMS));
  wire full    = (pair_cnt == 2'd2);
  wire accept  = pay_valid && pay_ready;

  assign pay_ready = rst_n && in_info && !tick && !full;
  assign sync_sh   = SYNC_WORD << sym_idx;

  always_comb begin
    if (!in_info) begin
      sgn  = sync_sh[SYNC_SYMS-1] ^ (frame_q == '0);
      mag3 = 1'b1;
    end else if (full) begin
      sgn  = pair_q[1];
      mag3 = !pair_q[0];
    end else begin
      sgn  = 1'b0;
      mag3 = 1'b1;
    end
  end

  wire [2:0] level = sgn ? (mag3 ? 3'b011 : 3'b001) : (mag3 ? 3'b101 : 3'b111);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      sym_idx   <= '0;
      frame_q   <= '0;
      pair_q    <= '0;
      pair_cnt  <= '0;
      sym_stb   <= 1'b0;
      sym_level <= '0;
      underrun  <= 1'b0;
      sf_start  <= 1'b0;
      frame_num <= '0;
    end else begin
      sym_stb  <= tick;
      underrun <= 1'b0;
      sf_start <= 1'b0;
      if (accept) begin
        if (pair_cnt == 2'd0) pair_q[1] <= pay_data;
        else                  pair_q[0] <= pay_data;
        pair_cnt <= pair_cnt + 2'd1;
      end
      if (tick) begin
        div_q     <= '0;
        sym_level <= level;
        underrun  <= in_info && !full;
        sf_start  <= (sym_idx == '0) && (frame_q == '0);
        frame_num <= frame_q;
        if (in_info) pair_cnt <= '0;
        if (sym_idx == SYMW'(SYMS_PER_FRAME - 1)) begin
          sym_idx <= '0;
          frame_q <= (frame_q == FRW'(FRAMES_PER_SF - 1)) ? '0 : frame_q + 1'b1;
        end else begin
          sym_idx <= sym_idx + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assert_stb_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> !sym_stb);
  assert_level_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |-> (sym_level == 3'b011 || sym_level == 3'b001 ||
                 sym_level == 3'b111 || sym_level == 3'b101));
  assert_no_accept_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (in_info && pair_cnt != 2'd2));
  assert_underrun_filler_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (sym_stb && sym_level == 3'b101));
  assert_sf_frame0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |-> (sym_stb && frame_num == '0));
endmodule

// File: tb/tb_dsl_superframe_tx.sv
module tb_dsl_superframe_tx;
  localparam int CPS = 4;
  localparam int NSYM = 2400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pay_data = 1'b0;
  logic pay_valid = 1'b0;
  logic pay_ready, sym_stb, underrun, sf_start;
  logic [2:0] sym_level;
  logic [2:0] frame_num;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  dsl_superframe_tx #(.CLKS_PER_SYM(CPS)) dut (
    .clk(clk), .rst_n(rst_n), .pay_data(pay_data), .pay_valid(pay_valid),
    .pay_ready(pay_ready), .sym_stb(sym_stb), .sym_level(sym_level),
    .underrun(underrun), .sf_start(sf_start), .frame_num(frame_num));

  always #5 clk = ~clk;

  function automatic logic [2:0] lvl(input bit s, input bit m3);
    return s ? (m3 ? 3'b011 : 3'b001) : (m3 ? 3'b101 : 3'b111);
  endfunction

  function automatic bit sync_sign(input int k);
    bit [8:0] w = 9'b110001011;
    return w[8-k];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int seed = 11;
    int k = 0, f = 0, nb = 0, nsym = 0, pct;
    int cyc = 0, last = 0;
    bit b0 = 0, b1 = 0, es, em;
    void'($urandom(seed));
    repeat (3) begin
      @(negedge clk);
      chk(sym_stb == 0 && underrun == 0 && sf_start == 0, "R8 reset outputs", sym_stb, 0);
      chk(pay_ready == 0 && frame_num == 0, "R8 reset ready/frame", pay_ready, 0);
    end
    rst_n = 1'b1;
    while (nsym < NSYM) begin
      @(negedge clk);
      cyc++;
      if (sym_stb) begin
        chk(cyc - last == CPS, "R1 strobe spacing", cyc - last, CPS);
        last = cyc;
        if (k < 9) begin
          es = sync_sign(k) ^ (f == 0); em = 1;
          chk(sym_level == lvl(es, em), (f == 0) ? "R3 inverted sync" : "R2 sync word",
              sym_level, lvl(es, em));
          chk(underrun == 0, "R6 no underrun in sync", underrun, 0);
        end else if (nb == 2) begin
          chk(sym_level == lvl(b1, !b0), "R4 pair mapping", sym_level, lvl(b1, !b0));
          chk(underrun == 0, "R6 underrun clear", underrun, 0);
        end else begin
          chk(sym_level == 3'b101, "R6 filler level", sym_level, 5);
          chk(underrun == 1, "R6 underrun flag", underrun, 1);
        end
        chk(frame_num == f[2:0], "R7 frame index", frame_num, f);
        chk(sf_start == (k == 0 && f == 0), "R7 superframe start", sf_start, k == 0 && f == 0);
        if (nsym == 0) chk(k == 0 && f == 0 && sf_start, "R8 first symbol", sf_start, 1);
        if (k >= 9) nb = 0;
        nsym++;
        k++;
        if (k == 120) begin k = 0; f = (f + 1) % 8; end
      end else begin
        chk(!underrun && !sf_start, "R1 flags only with strobe", underrun | sf_start, 0);
      end
      if (nsym < 960) pct = 95;
      else if (nsym < 1080) pct = 0;
      else if (nsym < 1400) pct = 30;
      else pct = 100;
      pay_valid = (($urandom % 100) < pct);
      pay_data = $urandom % 2;
      #1;
      if (pay_valid && pay_ready) begin
        chk(k >= 9, "R5 accept only in payload part", k, 9);
        chk(nb < 2, "R5 accept with pair full", nb, 1);
        if (nb == 0) b1 = pay_data; else b0 = pay_data;
        if (nb < 2) nb++;
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule